// File: doc/BRIEF.md
# CAN Bit-Time Timestamp Counter

This block keeps a 16-bit running count of CAN bit times for a CAN controller. A bit-time tick from the bit timing logic advances the count while the controller is enabled. When the controller finishes receiving or sending a frame through one of its message buffers, it pulses a strobe with that buffer's index. The block then writes the count into that buffer's time-stamp word in message RAM, through a single write port.

Nodes on the network can align their counts through synchronization. Software controls this with a control bit. While the bit is set, any completed frame in buffer 0 restarts the count at zero. Buffer 0 still receives the stamp taken just before the restart. Software can read the live count, and the control bit, through a small read port.

If a receive and a transmit finish in the same cycle, both stamps carry the same value. They are written one after the other, the receive stamp first. The write address is the buffer index times eight plus seven, which selects word 7 of an eight-word buffer.

Top module: `can_bittime_stamp`

## Requirements
- R1: After a synchronous reset, the count reads 0, synchronization is off (read-back bit 0 is 0) and no stamp write is issued.
- R2: While `mod_en` is high, each cycle with `bit_tick` high raises the count by one on the next clock edge. Cycles without a tick leave the count unchanged.
- R3: While `mod_en` is low, the count holds its value and ticks are ignored.
- R4: The count rolls over from 0xFFFF to 0x0000 on the next tick, with no other effect.
- R5: A `rx_done` pulse with a buffer index below 15 produces a stamp write one cycle later. The write has `stamp_addr` = index*8+7 and `stamp_data` equal to the count in the cycle of the pulse, even when a tick comes in that same cycle.
- R6: A `tx_done` pulse behaves the same way as R5, using `tx_buf` as the index.
- R7: If `rx_done` and `tx_done` arrive in the same cycle, the receive stamp is written one cycle later. The transmit stamp is written in the cycle after that. Both stamps carry the same count value.
- R8: A strobe whose buffer index is 15 or above produces no stamp write and does not restart the count.
- R9: While synchronization is on and `mod_en` is high, a completed frame in buffer 0 writes the pre-restart count to buffer 0. The count reads 0 on the next cycle, and a tick in that same cycle is ignored.
- R10: While synchronization is off, buffer 0 events are stamped normally and do not restart the count.
- R11: A `cfg_wr` pulse loads `cfg_sync_wdata` into the synchronization bit, which takes effect from the next cycle. `rd_data` shows the count when `rd_sel` is 0. When `rd_sel` is 1, it shows the synchronization bit in bit 0 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | 1 | CAN controller enabled |
| bit_tick | input | 1 | One pulse per CAN bit time |
| rx_done | input | 1 | Frame received successfully |
| rx_buf | input | 4 | Buffer that took the received frame |
| tx_done | input | 1 | Frame transmitted successfully |
| tx_buf | input | 4 | Buffer that sent the frame |
| cfg_wr | input | 1 | Write strobe for the control bit |
| cfg_sync_wdata | input | 1 | New synchronization enable value |
| rd_sel | input | 1 | Read select: 0 = count, 1 = control |
| rd_data | output | 16 | Read data |
| count | output | 16 | Live count |
| stamp_we | output | 1 | Stamp write enable to message RAM |
| stamp_addr | output | 7 | Word address of the time-stamp word |
| stamp_data | output | 16 | Stamp value |

## Verification
The count and the control bit change on the first clock edge after the cycle that causes the change. A stamp write appears one edge after its strobe. The transmit half of a same-cycle pair appears two edges after the strobe. The bench drives inputs on the falling edge and checks outputs on the next falling edge, so exactly one rising edge separates stimulus from check. For the paired case it checks on the second falling edge as well. Each capture test also checks the cycle after the write, to confirm that `stamp_we` has dropped.

// File: rtl/ts_pkg.sv
package ts_pkg;

    parameter int CNT_W = 16;
    parameter int IDX_W = 4;

    typedef logic [CNT_W-1:0] stamp_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } evt_t;

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        stamp_t           value;
    } wr_t;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } rd_sel_e;

    function automatic logic idx_in_range(input logic [IDX_W-1:0] idx, input int nbufs);
        return int'(idx) < nbufs;
    endfunction

    function automatic logic hits_buf0(input evt_t e);
        return e.valid && (e.idx == '0);
    endfunction

endpackage

// File: rtl/ts_counter.sv
module ts_counter
    import ts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   clr,
    output stamp_t cnt
);

    stamp_t cnt_q, cnt_n;

    always_comb begin
        cnt_n = cnt_q;
        if (en) begin
            if (clr)
                cnt_n = '0;
            else if (tick)
                cnt_n = cnt_q + stamp_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_n;
    end

    assign cnt = cnt_q;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !clr && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + stamp_t'(1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt_q));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !clr && cnt_q == '1) |=> (cnt_q == '0));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> (cnt_q == '0));

endmodule

// File: rtl/ts_capture.sv
module ts_capture
    import ts_pkg::*;
#(
    parameter int NUM_BUFS = 15
) (
    input  logic   clk,
    input  logic   rst,
    input  evt_t   rx_evt,
    input  evt_t   tx_evt,
    input  stamp_t cnt,
    output wr_t    wr
);

    wr_t  out_q, out_n;
    wr_t  pend_q, pend_n;
    logic rx_ok, tx_ok;
    wr_t  rx_w, tx_w;

    assign rx_ok = rx_evt.valid && idx_in_range(rx_evt.idx, NUM_BUFS);
    assign tx_ok = tx_evt.valid && idx_in_range(tx_evt.idx, NUM_BUFS);
    assign rx_w  = '{we: rx_ok, idx: rx_evt.idx, value: cnt};
    assign tx_w  = '{we: tx_ok, idx: tx_evt.idx, value: cnt};

    // One write slot per cycle: a waiting stamp goes first, then rx, then tx.
    always_comb begin
        out_n  = '0;
        pend_n = '0;
        if (pend_q.we) begin
            out_n = pend_q;
            if (rx_ok)      pend_n = rx_w;
            else if (tx_ok) pend_n = tx_w;
        end else if (rx_ok) begin
            out_n = rx_w;
            if (tx_ok) pend_n = tx_w;
        end else if (tx_ok) begin
            out_n = tx_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            pend_q <= '0;
        end else begin
            out_q  <= out_n;
            pend_q <= pend_n;
        end
    end

    assign wr = out_q;

    assert_rx_stamp_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_ok && !pend_q.we) |=> (out_q.we && out_q.idx == $past(rx_evt.idx) && out_q.value == $past(cnt)));

    assert_tx_stamp_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && !rx_ok && !pend_q.we) |=> (out_q.we && out_q.idx == $past(tx_evt.idx) && out_q.value == $past(cnt)));

    assert_pair_next_R7: assert property (@(posedge clk) disable iff (rst)
        pend_q.we |=> (out_q.we && out_q.value == $past(pend_q.value)));

    assert_range_R8: assert property (@(posedge clk) disable iff (rst)
        out_q.we |-> (int'(out_q.idx) < NUM_BUFS));

endmodule

// File: rtl/ts_sync_ctrl.sv
module ts_sync_ctrl
    import ts_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   cfg_wr,
    input  logic   cfg_wdata,
    input  logic   rd_sel,
    input  evt_t   rx_evt,
    input  evt_t   tx_evt,
    input  stamp_t cnt,
    output logic   clr,
    output stamp_t rd_data
);

    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst)         sync_q <= 1'b0;
        else if (cfg_wr) sync_q <= cfg_wdata;
    end

    assign clr = en && sync_q && (hits_buf0(rx_evt) || hits_buf0(tx_evt));

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            SEL_COUNT: rd_data = cnt;
            SEL_CTRL:  rd_data = stamp_t'(sync_q);
            default:   rd_data = '0;
        endcase
    end

    assert_cfg_load_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (sync_q == $past(cfg_wdata)));

    assert_cfg_keep_R11: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(sync_q));

endmodule

// File: rtl/can_bittime_stamp.sv
module can_bittime_stamp
    import ts_pkg::*;
#(
    parameter int NUM_BUFS      = 15,
    parameter int WORDS_PER_BUF = 8,
    parameter int STAMP_WORD    = 7,
    localparam int OFF_W        = $clog2(WORDS_PER_BUF),
    localparam int ADDR_W       = IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mod_en,
    input  logic              bit_tick,
    input  logic              rx_done,
    input  logic [IDX_W-1:0]  rx_buf,
    input  logic              tx_done,
    input  logic [IDX_W-1:0]  tx_buf,
    input  logic              cfg_wr,
    input  logic              cfg_sync_wdata,
    input  logic              rd_sel,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              stamp_we,
    output logic [ADDR_W-1:0] stamp_addr,
    output logic [CNT_W-1:0]  stamp_data
);

    evt_t   rx_evt, tx_evt;
    stamp_t cnt;
    logic   clr;
    wr_t    wr;

    assign rx_evt = '{valid: rx_done, idx: rx_buf};
    assign tx_evt = '{valid: tx_done, idx: tx_buf};

    ts_sync_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .en        (mod_en),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_sync_wdata),
        .rd_sel    (rd_sel),
        .rx_evt    (rx_evt),
        .tx_evt    (tx_evt),
        .cnt       (cnt),
        .clr       (clr),
        .rd_data   (rd_data)
    );

    ts_counter u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (mod_en),
        .tick (bit_tick),
        .clr  (clr),
        .cnt  (cnt)
    );

    ts_capture #(.NUM_BUFS(NUM_BUFS)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .rx_evt (rx_evt),
        .tx_evt (tx_evt),
        .cnt    (cnt),
        .wr     (wr)
    );

    assign count      = cnt;
    assign stamp_we   = wr.we;
    assign stamp_addr = {wr.idx, OFF_W'(STAMP_WORD)};
    assign stamp_data = wr.value;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!stamp_we && count == '0));

endmodule

// File: tb/can_bittime_stamp_tb_top.sv
module can_bittime_stamp_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst, mod_en, bit_tick, rx_done, tx_done, cfg_wr, cfg_sync_wdata, rd_sel;
    logic [3:0]  rx_buf, tx_buf;
    logic [15:0] rd_data, count, stamp_data;
    logic        stamp_we;
    logic [6:0]  stamp_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bittime_stamp dut_i (
        .clk(clk), .rst(rst), .mod_en(mod_en), .bit_tick(bit_tick),
        .rx_done(rx_done), .rx_buf(rx_buf), .tx_done(tx_done), .tx_buf(tx_buf),
        .cfg_wr(cfg_wr), .cfg_sync_wdata(cfg_sync_wdata), .rd_sel(rd_sel),
        .rd_data(rd_data), .count(count), .stamp_we(stamp_we),
        .stamp_addr(stamp_addr), .stamp_data(stamp_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        bit_tick = 0; rx_done = 0; tx_done = 0; cfg_wr = 0;
    endtask

    task automatic do_ticks(input int n);
        bit_tick = 1;
        repeat (n) step();
        bit_tick = 0;
    endtask

    task automatic t_reset();
        rst = 1; mod_en = 0; clear_strobes(); rx_buf = 0; tx_buf = 0;
        cfg_sync_wdata = 0; rd_sel = 0;
        repeat (3) step();
        rst = 0; mod_en = 1;
        step();
        chk("R1 count", count, 0);
        chk("R1 we", stamp_we, 0);
        rd_sel = 1; #1;
        chk("R1 sync bit", rd_data, 0);
        rd_sel = 0;
    endtask

    task automatic t_count();
        do_ticks(5);
        chk("R2 five ticks", count, 5);
        repeat (3) step();
        chk("R2 no tick hold", count, 5);
        #1 chk("R11 read count", rd_data, 5);
    endtask

    task automatic t_disable();
        mod_en = 0;
        do_ticks(4);
        chk("R3 disabled hold", count, 5);
        mod_en = 1;
    endtask

    task automatic t_rx_capture();
        rx_done = 1; rx_buf = 3;
        step(); rx_done = 0;
        chk("R5 we", stamp_we, 1);
        chk("R5 addr", stamp_addr, 31);
        chk("R5 data", stamp_data, 5);
        step();
        chk("R5 we drops", stamp_we, 0);
    endtask

    task automatic t_tx_capture();
        tx_done = 1; tx_buf = 14; bit_tick = 1;
        step(); tx_done = 0; bit_tick = 0;
        chk("R6 we", stamp_we, 1);
        chk("R6 addr", stamp_addr, 119);
        chk("R6 data pre-tick", stamp_data, 5);
        chk("R6 count ticked", count, 6);
        step();
        chk("R6 we drops", stamp_we, 0);
    endtask

    task automatic t_pair();
        rx_done = 1; rx_buf = 2; tx_done = 1; tx_buf = 5;
        step(); clear_strobes();
        chk("R7 first we", stamp_we, 1);
        chk("R7 first addr", stamp_addr, 23);
        chk("R7 first data", stamp_data, 6);
        step();
        chk("R7 second we", stamp_we, 1);
        chk("R7 second addr", stamp_addr, 47);
        chk("R7 second data", stamp_data, 6);
        step();
        chk("R7 we drops", stamp_we, 0);
    endtask

    task automatic t_bad_idx();
        rx_done = 1; rx_buf = 15;
        step(); rx_done = 0;
        chk("R8 no write", stamp_we, 0);
        chk("R8 count kept", count, 6);
    endtask

    task automatic t_sync_off();
        rx_done = 1; rx_buf = 0;
        step(); rx_done = 0;
        chk("R10 stamp", stamp_data, 6);
        chk("R10 addr", stamp_addr, 7);
        chk("R10 no restart", count, 6);
    endtask

    task automatic t_sync_on();
        cfg_wr = 1; cfg_sync_wdata = 1;
        step(); cfg_wr = 0;
        rd_sel = 1; #1;
        chk("R11 sync bit read", rd_data, 1);
        rd_sel = 0;
        tx_done = 1; tx_buf = 0; bit_tick = 1;
        step(); clear_strobes();
        chk("R9 we", stamp_we, 1);
        chk("R9 pre-restart stamp", stamp_data, 6);
        chk("R9 restarted", count, 0);
        // bad index 15 with sync on must not restart
        do_ticks(2);
        rx_done = 1; rx_buf = 15;
        step(); rx_done = 0;
        chk("R8 no restart on bad index", count, 2);
    endtask

    task automatic t_wrap();
        rx_done = 1; rx_buf = 0;
        step(); rx_done = 0;
        chk("R9 restart again", count, 0);
        do_ticks(65535);
        chk("R4 top value", count, 16'hFFFF);
        do_ticks(1);
        chk("R4 rollover", count, 0);
        chk("R4 no write", stamp_we, 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_count();
        t_disable();
        t_rx_capture();
        t_tx_capture();
        t_pair();
        t_bad_idx();
        t_sync_off();
        t_sync_on();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule